// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Aligned Commit

This block produces the raster timing for one display output: horizontal sync, vertical sync, a data-enable strobe and the pixel coordinates of the active window. Two counters run on the pixel clock. The horizontal counter counts pixel clocks within a line. The vertical counter counts lines within a frame. Each output is a comparison of a counter against a programmed boundary.

Software sets the timing through a small synchronous register port. Timing writes land in a staging bank and have no effect on the outputs until a commit is requested. The staged set is copied into the working set at the first frame boundary after the request. The raster therefore never shows a frame built from a mix of old and new values. Standby and the output polarities are plain control bits that act at once. In standby the counters are held at zero and every strobe sits at its inactive level.

Top module: `rtg_top`

## Requirements
- R1: While reset is asserted, the counters sit at line 0, pixel 0. The registers read back their parameter defaults: timing values, a polarity field of 4'b0100, standby clear and no pending commit.
- R2: Each line starts with the horizontal counter at 0. Horizontal sync is active while the counter is below the sync-end value. The line lasts exactly the programmed horizontal total, in clocks.
- R3: Data enable is active only while the horizontal counter is in [start, end) and the vertical counter is in its own [start, end). Both end values are exclusive.
- R4: The vertical counter advances by one at each line wrap and returns to 0 after the programmed vertical total. Vertical sync is active while the vertical counter is below its sync-end value.
- R5: While data enable is active, the pixel x output equals the horizontal counter minus the horizontal active start, and y equals the vertical counter minus the vertical active start. Both outputs are 0 outside the active window.
- R6: There are four timing registers, at byte offsets 0x10, 0x14, 0x18 and 0x1C. Each holds one 13-bit value in bits [28:16] and another in bits [12:0]. 0x10 holds the horizontal total (high) and horizontal sync end (low). 0x14 holds the horizontal active start (high) and end (low). 0x18 and 0x1C hold the same pairs for the vertical direction. Reads return the staged values.
- R7: Writing 1 to bit 0 at offset 0x00 sets a pending flag, which reads back on bit 0. The staged set is copied to the working set on the clock edge that starts the next frame. The flag clears on that same edge.
- R8: Without a commit, writes to the timing registers leave the outputs unchanged.
- R9: Bit 22 at offset 0x08 selects standby. While it is set, both counters are held at 0, the strobes drive their inactive levels, x and y read 0, and register writes and commits are still accepted. A commit is applied on the next edge in standby. Clearing the bit restarts the raster from the start of a frame.
- R10: Bits [3:0] at offset 0x08 set the polarities: bit 0 hsync, bit 1 vsync, bit 2 data enable, bit 3 the pixel-clock inversion output. A 1 means active-high. A change takes effect on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (8) | Byte offset, word aligned |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| hsync_o | output | 1 | Horizontal sync at its programmed polarity |
| vsync_o | output | 1 | Vertical sync at its programmed polarity |
| de_o | output | 1 | Data enable at its programmed polarity |
| pclk_inv_o | output | 1 | Pixel-clock inversion select for the output stage |
| pix_x_o | output | TW (13) | Column within the active window |
| pix_y_o | output | TW (13) | Row within the active window |

## Verification
The hardest case is the commit that lands mid-frame. Staged values must stay invisible until the exact edge that wraps both counters, and the commit flag must still read back as set in the meantime. The bench stages a new geometry, reads it back and lets most of a frame pass. It then requests the commit at an arbitrary point in the frame. A cycle-accurate reference model steps beside the design and predicts every strobe and coordinate on every clock, so a load one edge early or late shows up at once. A second commit is issued during standby, to a geometry whose active window touches both the line end and the frame end, which exercises the exclusive end bounds.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // register offsets (bytes)
   localparam int OFS_COMMIT = 'h00;
   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_TIM0   = 'h10;
   localparam int N_TIM_REG  = 4;
   // bit positions
   localparam int COMMIT_BIT = 0;
   localparam int STBY_BIT   = 22;
   localparam int HI_LSB     = 16;
   localparam int POL_W      = 4;
   localparam int POL_HS     = 0;
   localparam int POL_VS     = 1;
   localparam int POL_DE     = 2;
   localparam int POL_PCLK   = 3;
   localparam int MAX_TW     = 13;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int TW = 13,
   parameter int AW = 8,
   parameter int DW = 32,
   parameter int H_TOTAL_RST = 14,
   parameter int H_SYNC_RST  = 2,
   parameter int H_AST_RST   = 4,
   parameter int H_AEND_RST  = 12,
   parameter int V_TOTAL_RST = 8,
   parameter int V_SYNC_RST  = 1,
   parameter int V_AST_RST   = 2,
   parameter int V_AEND_RST  = 6,
   parameter logic [3:0] POL_RST = 4'b0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          frame_wrap_i,
   output logic          load_o,
   output logic          stby_o,
   output logic [POL_W-1:0] pol_o,
   output logic [TW-1:0] wrk_hi_o [N_TIM_REG],
   output logic [TW-1:0] wrk_lo_o [N_TIM_REG]
);
   localparam logic [AW-1:0] A_COMMIT = AW'(OFS_COMMIT);
   localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);

   if (TW > MAX_TW) begin : g_bad_tw
      $error("rtg_regs: TW must not exceed the 13-bit packed field");
   end
   if (DW != 32) begin : g_bad_dw
      $error("rtg_regs: DW must be 32");
   end
   if (AW < 6) begin : g_bad_aw
      $error("rtg_regs: AW too small for the register map");
   end

   logic pend_q, stby_q;
   logic [POL_W-1:0] pol_q;
   logic [TW-1:0] stg_hi [N_TIM_REG];
   logic [TW-1:0] stg_lo [N_TIM_REG];
   logic commit_we, ctrl_we;

   assign commit_we = bus_we && (bus_addr == A_COMMIT) && bus_wdata[COMMIT_BIT];
   assign ctrl_we   = bus_we && (bus_addr == A_CTRL);
   assign load_o    = pend_q && (stby_q || frame_wrap_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         stby_q <= 1'b0;
         pol_q  <= POL_RST;
      end else begin
         if (commit_we)   pend_q <= 1'b1;
         else if (load_o) pend_q <= 1'b0;
         if (ctrl_we) begin
            stby_q <= bus_wdata[STBY_BIT];
            pol_q  <= bus_wdata[POL_W-1:0];
         end
      end
   end

   for (genvar k = 0; k < N_TIM_REG; k++) begin : g_tim
      localparam logic [AW-1:0] A_REG = AW'(OFS_TIM0 + 4 * k);
      localparam logic [TW-1:0] R_HI = (k == 0) ? TW'(H_TOTAL_RST) :
                                       (k == 1) ? TW'(H_AST_RST)   :
                                       (k == 2) ? TW'(V_TOTAL_RST) : TW'(V_AST_RST);
      localparam logic [TW-1:0] R_LO = (k == 0) ? TW'(H_SYNC_RST)  :
                                       (k == 1) ? TW'(H_AEND_RST)  :
                                       (k == 2) ? TW'(V_SYNC_RST)  : TW'(V_AEND_RST);
      logic [TW-1:0] s_hi_q, s_lo_q, w_hi_q, w_lo_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_hi_q <= R_HI;
            s_lo_q <= R_LO;
            w_hi_q <= R_HI;
            w_lo_q <= R_LO;
         end else begin
            if (load_o) begin
               w_hi_q <= s_hi_q;
               w_lo_q <= s_lo_q;
            end
            if (bus_we && bus_addr == A_REG) begin
               s_hi_q <= bus_wdata[HI_LSB +: TW];
               s_lo_q <= bus_wdata[0 +: TW];
            end
         end
      end
      assign stg_hi[k]   = s_hi_q;
      assign stg_lo[k]   = s_lo_q;
      assign wrk_hi_o[k] = w_hi_q;
      assign wrk_lo_o[k] = w_lo_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_COMMIT) begin
         bus_rdata[COMMIT_BIT] = pend_q;
      end else if (bus_addr == A_CTRL) begin
         bus_rdata[STBY_BIT]    = stby_q;
         bus_rdata[POL_W-1:0]   = pol_q;
      end else begin
         for (int k = 0; k < N_TIM_REG; k++) begin
            if (bus_addr == AW'(OFS_TIM0 + 4 * k)) begin
               bus_rdata[HI_LSB +: TW] = stg_hi[k];
               bus_rdata[0 +: TW]      = stg_lo[k];
            end
         end
      end
   end

   assign stby_o = stby_q;
   assign pol_o  = pol_q;

   // R7: a load without a new request leaves nothing pending
   p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && !commit_we) |=> !pend_q);

   // R8: the working set only moves on a load
   p_wrk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_o |=> $stable({wrk_hi_o[0], wrk_lo_o[0], wrk_hi_o[1], wrk_lo_o[1],
                           wrk_hi_o[2], wrk_lo_o[2], wrk_hi_o[3], wrk_lo_o[3]}));
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
   parameter int TW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic [TW-1:0] total_i,
   input  logic [TW-1:0] sync_end_i,
   input  logic [TW-1:0] act_st_i,
   input  logic [TW-1:0] act_end_i,
   output logic [TW-1:0] cnt_o,
   output logic          wrap_o,
   output logic          sync_o,
   output logic          act_o,
   output logic [TW-1:0] pos_o
);
   logic [TW-1:0] cnt_q;
   logic [TW:0]   nxt;

   assign nxt    = {1'b0, cnt_q} + 1'b1;
   assign wrap_o = nxt >= {1'b0, total_i};

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (step_i) cnt_q <= wrap_o ? '0 : nxt[TW-1:0];
   end

   assign sync_o = cnt_q < sync_end_i;
   assign act_o  = (cnt_q >= act_st_i) && (cnt_q < act_end_i);
   assign pos_o  = cnt_q - act_st_i;
   assign cnt_o  = cnt_q;

   // R2/R4: the count stays inside the programmed total
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (total_i != '0) |-> (cnt_q < total_i));

   // R2/R4: a wrap returns the counter to zero
   p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && wrap_o && !clr_i) |=> (cnt_q == '0));

   // R9: standby holds the counter at zero
   p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtg_outenc.sv
module rtg_outenc
   import rtg_pkg::*;
#(
   parameter int TW = 13
) (
   input  logic             stby_i,
   input  logic [POL_W-1:0] pol_i,
   input  logic             hs_i,
   input  logic             vs_i,
   input  logic             hact_i,
   input  logic             vact_i,
   input  logic [TW-1:0]    hpos_i,
   input  logic [TW-1:0]    vpos_i,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic             pclk_inv_o,
   output logic [TW-1:0]    x_o,
   output logic [TW-1:0]    y_o
);
   localparam int NSIG = 3;
   logic [NSIG-1:0] act, lvl;
   logic de_raw;

   assign de_raw = !stby_i && hact_i && vact_i;
   assign act[POL_HS] = !stby_i && hs_i;
   assign act[POL_VS] = !stby_i && vs_i;
   assign act[POL_DE] = de_raw;

   for (genvar g = 0; g < NSIG; g++) begin : g_pol
      assign lvl[g] = pol_i[g] ? act[g] : !act[g];
   end

   assign hsync_o    = lvl[POL_HS];
   assign vsync_o    = lvl[POL_VS];
   assign de_o       = lvl[POL_DE];
   assign pclk_inv_o = pol_i[POL_PCLK];
   assign x_o        = de_raw ? hpos_i : '0;
   assign y_o        = de_raw ? vpos_i : '0;
endmodule

// File: rtl/rtg_top.sv
module rtg_top
   import rtg_pkg::*;
#(
   parameter int TW = 13,
   parameter int AW = 8,
   parameter int DW = 32,
   parameter int H_TOTAL_RST = 14,
   parameter int H_SYNC_RST  = 2,
   parameter int H_AST_RST   = 4,
   parameter int H_AEND_RST  = 12,
   parameter int V_TOTAL_RST = 8,
   parameter int V_SYNC_RST  = 1,
   parameter int V_AST_RST   = 2,
   parameter int V_AEND_RST  = 6,
   parameter logic [3:0] POL_RST = 4'b0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          pclk_inv_o,
   output logic [TW-1:0] pix_x_o,
   output logic [TW-1:0] pix_y_o
);
   logic [TW-1:0] wrk_hi [N_TIM_REG];
   logic [TW-1:0] wrk_lo [N_TIM_REG];
   logic stby, load;
   logic [POL_W-1:0] pol;
   logic [TW-1:0] h_cnt, v_cnt, h_pos, v_pos;
   logic h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;

   rtg_regs #(
      .TW(TW), .AW(AW), .DW(DW),
      .H_TOTAL_RST(H_TOTAL_RST), .H_SYNC_RST(H_SYNC_RST),
      .H_AST_RST(H_AST_RST), .H_AEND_RST(H_AEND_RST),
      .V_TOTAL_RST(V_TOTAL_RST), .V_SYNC_RST(V_SYNC_RST),
      .V_AST_RST(V_AST_RST), .V_AEND_RST(V_AEND_RST),
      .POL_RST(POL_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .frame_wrap_i(h_wrap && v_wrap),
      .load_o(load), .stby_o(stby), .pol_o(pol),
      .wrk_hi_o(wrk_hi), .wrk_lo_o(wrk_lo)
   );

   rtg_axis #(.TW(TW)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .clr_i(stby), .step_i(1'b1),
      .total_i(wrk_hi[0]), .sync_end_i(wrk_lo[0]),
      .act_st_i(wrk_hi[1]), .act_end_i(wrk_lo[1]),
      .cnt_o(h_cnt), .wrap_o(h_wrap), .sync_o(h_sync), .act_o(h_act), .pos_o(h_pos)
   );

   rtg_axis #(.TW(TW)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .clr_i(stby), .step_i(h_wrap),
      .total_i(wrk_hi[2]), .sync_end_i(wrk_lo[2]),
      .act_st_i(wrk_hi[3]), .act_end_i(wrk_lo[3]),
      .cnt_o(v_cnt), .wrap_o(v_wrap), .sync_o(v_sync), .act_o(v_act), .pos_o(v_pos)
   );

   rtg_outenc #(.TW(TW)) u_enc (
      .stby_i(stby), .pol_i(pol),
      .hs_i(h_sync), .vs_i(v_sync), .hact_i(h_act), .vact_i(v_act),
      .hpos_i(h_pos), .vpos_i(v_pos),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_inv_o(pclk_inv_o),
      .x_o(pix_x_o), .y_o(pix_y_o)
   );

   // R7: a new working set always begins at line 0, pixel 0
   p_load_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (h_cnt == '0 && v_cnt == '0));

   // R4: a line wrap inside a frame advances the line count by one
   p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wrap && !v_wrap && !stby) |=> (v_cnt == TW'($past(v_cnt) + 1'b1)));
endmodule

// File: tb/rtg_top_bench.sv
`timescale 1ns/1ps
module rtg_top_bench;
   localparam int TW = 13;
   localparam int AW = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bw = 1'b0;
   logic [AW-1:0] ba = '0;
   logic [DW-1:0] bd = '0;
   logic [DW-1:0] rdata;
   logic hsync_o, vsync_o, de_o, pclk_inv_o;
   logic [TW-1:0] pix_x_o, pix_y_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rtg_top u_rtg_top (
      .clk(clk), .rst_n(rst_n), .bus_we(bw), .bus_addr(ba), .bus_wdata(bd),
      .bus_rdata(rdata), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .pclk_inv_o(pclk_inv_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
   );

   typedef struct {
      bit hs; bit vs; bit de; bit pc; int x; int y;
   } exp_t;
   exp_t q[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: defaults and field map from R1/R6
   int sh_hi[4], sh_lo[4], wk_hi[4], wk_lo[4];
   int mh, mv, m_pol;
   bit m_pend, m_stby;

   task automatic model_reset();
      sh_hi = '{14, 4, 8, 2}; sh_lo = '{2, 12, 1, 6};
      wk_hi = sh_hi; wk_lo = sh_lo;
      mh = 0; mv = 0; m_pol = 4; m_pend = 0; m_stby = 0;
   endtask

   initial model_reset();

   // driver side of the scoreboard: predict the state after each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit hw, vw, ld, hs, vs, de;
         exp_t e;
         hw = (mh + 1) >= wk_hi[0];
         vw = (mv + 1) >= wk_hi[2];
         ld = m_pend && (m_stby || (hw && vw));
         if (m_stby) begin mh = 0; mv = 0; end
         else if (hw) begin mh = 0; mv = vw ? 0 : mv + 1; end
         else mh = mh + 1;
         if (ld) begin wk_hi = sh_hi; wk_lo = sh_lo; m_pend = 0; end
         if (bw) begin
            if (ba == 8'h00 && bd[0]) m_pend = 1;
            if (ba == 8'h08) begin m_stby = bd[22]; m_pol = int'(bd[3:0]); end
            if (ba >= 8'h10 && ba <= 8'h1C && ba[1:0] == 2'b00) begin
               sh_hi[(ba - 8'h10) / 4] = int'(bd[28:16]);
               sh_lo[(ba - 8'h10) / 4] = int'(bd[12:0]);
            end
         end
         hs = !m_stby && (mh < wk_lo[0]);
         vs = !m_stby && (mv < wk_lo[2]);
         de = !m_stby && mh >= wk_hi[1] && mh < wk_lo[1] && mv >= wk_hi[3] && mv < wk_lo[3];
         e.hs = m_pol[0] ? hs : !hs;
         e.vs = m_pol[1] ? vs : !vs;
         e.de = m_pol[2] ? de : !de;
         e.pc = m_pol[3];
         e.x  = de ? mh - wk_hi[1] : 0;
         e.y  = de ? mv - wk_hi[3] : 0;
         q.push_back(e);
      end
   end

   // monitor side: compare away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(hsync_o == e.hs, "R2/R8 hsync", int'(hsync_o), int'(e.hs));
         chk(vsync_o == e.vs, "R4/R8 vsync", int'(vsync_o), int'(e.vs));
         chk(de_o == e.de, "R3 data enable", int'(de_o), int'(e.de));
         chk(pclk_inv_o == e.pc, "R10 pclk polarity", int'(pclk_inv_o), int'(e.pc));
         chk(int'(pix_x_o) == e.x, "R5 pixel x", int'(pix_x_o), e.x);
         chk(int'(pix_y_o) == e.y, "R5 pixel y", int'(pix_y_o), e.y);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bw = 1'b1; ba = AW'(a); bd = DW'(d);
      @(negedge clk);
      bw = 1'b0;
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      ba = AW'(a);
      #1;
      chk(rdata == DW'(exp), tag, int'(rdata), exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      // R1: reset state
      chk(hsync_o == 1'b0, "R1 hsync in reset", int'(hsync_o), 0);
      chk(vsync_o == 1'b0, "R1 vsync in reset", int'(vsync_o), 0);
      chk(de_o == 1'b0, "R1 de in reset", int'(de_o), 0);
      chk(pix_x_o == '0, "R1 x in reset", int'(pix_x_o), 0);
      rd('h10, (14 << 16) | 2, "R1 htiming default");
      rd('h1C, (2 << 16) | 6, "R1 vactive default");
      rd('h08, 4, "R1 ctrl default");
      rd('h00, 0, "R1 no pending commit");
      rst_n = 1'b1;
      idle(230);

      // R6/R8: stage a new geometry without committing
      wr('h10, (20 << 16) | 3);
      wr('h14, (5 << 16) | 17);
      wr('h18, (6 << 16) | 2);
      wr('h1C, (3 << 16) | 5);
      rd('h10, (20 << 16) | 3, "R6 staged htotal/hsync readback");
      rd('h18, (6 << 16) | 2, "R6 staged vtotal/vsync readback");
      rd('h00, 0, "R8 nothing pending before commit");
      idle(120);

      // R7: mid-frame commit, applied at the next frame start
      wr('h00, 1);
      rd('h00, 1, "R7 commit pending");
      idle(150);
      rd('h00, 0, "R7 commit cleared at frame start");
      idle(260);

      // R10: all active-high, pixel clock inverted
      wr('h08, 'hF);
      chk(pclk_inv_o == 1'b1, "R10 pclk inversion", int'(pclk_inv_o), 1);
      idle(130);

      // R9: standby, with writes and a commit accepted meanwhile
      wr('h08, (1 << 22) | 'hF);
      idle(3);
      chk(hsync_o == 1'b0, "R9 hsync idle", int'(hsync_o), 0);
      chk(vsync_o == 1'b0, "R9 vsync idle", int'(vsync_o), 0);
      chk(de_o == 1'b0, "R9 de idle", int'(de_o), 0);
      chk(pix_y_o == '0, "R9 y idle", int'(pix_y_o), 0);
      wr('h10, (10 << 16) | 1);
      wr('h14, 10);
      wr('h18, (4 << 16) | 1);
      wr('h1C, 4);
      wr('h00, 1);
      idle(1);
      rd('h00, 0, "R9 commit taken in standby");
      rd('h14, 10, "R6 hactive readback");
      rd('h08, (1 << 22) | 'hF, "R9 standby readback");
      idle(5);
      // R3/R5: active window reaching the line and frame ends
      wr('h08, 4);
      idle(100);

      idle(2);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule